// File: doc/BRIEF.md
# Digital Window Comparator Bank

The block holds a bank of comparator units that watch converted samples. A sequence step sends a sample to one unit by strobing `smp_valid_i` with the unit index on `smp_sel_i`. The unit compares the sample against its two programmed references and places it in one of three bands:

- low, when the sample is below the lower reference;
- mid, when the sample lies between the references, with either reference value itself counting as mid;
- high, when the sample is above the upper reference.

Each unit evaluates two conditions independently. One drives a one-cycle pulse on its trigger output. The other sets a sticky bit in a shared status vector. Each condition has its own mode, target band and history of earlier bands.

The status vector does not record which sequencer delivered the sample. Software clears status bits by pulsing the matching bits of `irq_clr_i`. A separate history-reset command wipes the trigger history, the status history, or both, for one unit. This stops stale bands from influencing the decisions that follow.

Top module: `wcmp_bank`

## Requirements
- R1: A sample below the low reference is in band low (code 0). A sample above the high reference is in band high (code 2). Any other sample, including one equal to either reference, is in band mid (code 1).
- R2: In mode 0 (always), a condition fires on every routed sample whose band equals the target band. For the trigger condition, bit i of `trig_o` goes high for exactly the one cycle after the clock edge that captured the sample.
- R3: In mode 1 (once), a condition fires only when the band equals the target, the previous sample was seen since the last history reset, and the previous band differs from the target. The first sample after reset never fires.
- R4: Mode 2 (hysteresis, always) applies to a low or high target. The condition fires when the band equals the target. It also fires when the band is mid and the most recent non-mid band since the last history reset was the target.
- R5: Mode 3 (hysteresis, once) applies to a low or high target. The condition fires when the band equals the target and a non-mid band has been seen since the last history reset, with the most recent such band not being the target.
- R6: Target band code 3 disables a condition in every mode. A mid target never fires in modes 2 or 3.
- R7: Status bit i is set on the edge after a routed sample makes unit i's status condition fire, and then holds. A 1 on `irq_clr_i[i]` clears it on the next edge. A set in the same cycle as a clear wins over the clear.
- R8: The trigger condition and the status condition of a unit have separate mode and target settings. Each decides without reference to the other.
- R9: A history reset of one unit with `hrst_trig_i` clears only the trigger history, and with `hrst_irq_i` clears only the status history. A cleared history counts as never having seen a sample.
- R10: A sample affects only the unit named by `smp_sel_i`. Outputs and history of other units are unchanged.
- R11: After reset, `trig_o` and `irq_status_o` are zero and every unit has both conditions disabled (target code 3).
- R12: A configuration write changes only the unit named by `cfg_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | SEL_W | Unit written by configuration |
| cfg_lo_i | input | DATA_W | Lower reference (low/mid boundary) |
| cfg_hi_i | input | DATA_W | Upper reference (mid/high boundary) |
| cfg_trig_mode_i | input | 2 | Trigger condition mode |
| cfg_trig_band_i | input | 2 | Trigger condition target band |
| cfg_irq_mode_i | input | 2 | Status condition mode |
| cfg_irq_band_i | input | 2 | Status condition target band |
| smp_valid_i | input | 1 | Sample strobe |
| smp_sel_i | input | SEL_W | Unit receiving the sample |
| smp_data_i | input | DATA_W | Sample value |
| hrst_i | input | 1 | History reset strobe |
| hrst_sel_i | input | SEL_W | Unit whose history is reset |
| hrst_trig_i | input | 1 | Reset the trigger history |
| hrst_irq_i | input | 1 | Reset the status history |
| irq_clr_i | input | N_UNITS | Write-one-to-clear status mask |
| trig_o | output | N_UNITS | Trigger pulses, one per unit |
| irq_status_o | output | N_UNITS | Sticky status bits, one per unit |

## Verification
Both decisions are registered once. The trigger pulse and any new status bit therefore appear on the first rising edge after the sample strobe, and a status clear takes effect on the first rising edge after the clear mask. The bench changes inputs on falling edges and reads the outputs on the falling edge after the edge that captured them. It removes the strobe in that same step, so each read shows exactly one sample's decision. Stickiness and the one-cycle width of the pulse are checked with additional idle cycles before reading.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;
  typedef enum logic [1:0] {
    BAND_LO  = 2'd0,
    BAND_MID = 2'd1,
    BAND_HI  = 2'd2,
    BAND_OFF = 2'd3
  } band_e;

  typedef enum logic [1:0] {
    MODE_ALWAYS    = 2'd0,
    MODE_ONCE      = 2'd1,
    MODE_HYST      = 2'd2,
    MODE_HYST_ONCE = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e mode;
    band_e band;
  } cond_t;

  // prev: band of last sample; ext: last non-mid band
  typedef struct packed {
    band_e prev;
    logic  prev_v;
    band_e ext;
    logic  ext_v;
  } hist_t;

  localparam cond_t COND_OFF = '{mode: MODE_ALWAYS, band: BAND_OFF};
  localparam int    N_COND   = 2;  // 0: trigger, 1: status
endpackage

// File: rtl/wcmp_classify.sv
module wcmp_classify
  import wcmp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] smp_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output band_e             band_o
);
  always_comb begin
    if (smp_i < lo_i)      band_o = BAND_LO;
    else if (smp_i > hi_i) band_o = BAND_HI;
    else                   band_o = BAND_MID;
  end
endmodule

// File: rtl/wcmp_decide.sv
module wcmp_decide
  import wcmp_pkg::*;
(
  input  cond_t cond_i,
  input  hist_t hist_i,
  input  band_e cur_i,
  output logic  fire_o
);
  logic hit, extreme_tgt;

  assign hit         = (cond_i.band != BAND_OFF) && (cur_i == cond_i.band);
  assign extreme_tgt = (cond_i.band == BAND_LO) || (cond_i.band == BAND_HI);

  always_comb begin
    unique case (cond_i.mode)
      MODE_ALWAYS:    fire_o = hit;
      MODE_ONCE:      fire_o = hit && hist_i.prev_v && (hist_i.prev != cond_i.band);
      MODE_HYST:      fire_o = extreme_tgt &&
                               (hit || (cur_i == BAND_MID && hist_i.ext_v &&
                                        hist_i.ext == cond_i.band));
      MODE_HYST_ONCE: fire_o = extreme_tgt && hit && hist_i.ext_v &&
                               (hist_i.ext != cond_i.band);
      default:        fire_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wcmp_unit.sv
module wcmp_unit
  import wcmp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_lo_i,
  input  logic [DATA_W-1:0] cfg_hi_i,
  input  cond_t             trig_cfg_i,
  input  cond_t             irq_cfg_i,
  input  logic              smp_we_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              hrst_trig_i,
  input  logic              hrst_irq_i,
  input  logic              irq_clr_i,
  output logic              trig_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] lo_q, hi_q;
  band_e             cur_band;
  logic [N_COND-1:0] fire;
  logic [N_COND-1:0] hrst;

  assign hrst = {hrst_irq_i, hrst_trig_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cfg_we_i) begin
      lo_q <= cfg_lo_i;
      hi_q <= cfg_hi_i;
    end
  end

  wcmp_classify #(.DATA_W(DATA_W)) u_cls (
    .smp_i (smp_i),
    .lo_i  (lo_q),
    .hi_i  (hi_q),
    .band_o(cur_band)
  );

  for (genvar g = 0; g < N_COND; g++) begin : g_cond
    cond_t cond_q;
    hist_t hist_q;
    cond_t cond_new;
    logic  fire_c;

    assign cond_new = (g == 0) ? trig_cfg_i : irq_cfg_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cond_q <= COND_OFF;
      else if (cfg_we_i) cond_q <= cond_new;
    end

    // history reset wins over a sample in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hist_q <= '0;
      end else if (hrst[g]) begin
        hist_q <= '0;
      end else if (smp_we_i) begin
        hist_q.prev   <= cur_band;
        hist_q.prev_v <= 1'b1;
        if (cur_band != BAND_MID) begin
          hist_q.ext   <= cur_band;
          hist_q.ext_v <= 1'b1;
        end
      end
    end

    wcmp_decide u_dec (
      .cond_i(cond_q),
      .hist_i(hist_q),
      .cur_i (cur_band),
      .fire_o(fire_c)
    );

    assign fire[g] = fire_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      trig_o <= smp_we_i && fire[0];
      irq_o  <= (irq_o && !irq_clr_i) || (smp_we_i && fire[1]);
    end
  end
endmodule

// File: rtl/wcmp_bank.sv
module wcmp_bank
  import wcmp_pkg::*;
#(
  parameter int N_UNITS = 8,
  parameter int DATA_W  = 12,
  localparam int SEL_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic [DATA_W-1:0]  cfg_lo_i,
  input  logic [DATA_W-1:0]  cfg_hi_i,
  input  logic [1:0]         cfg_trig_mode_i,
  input  logic [1:0]         cfg_trig_band_i,
  input  logic [1:0]         cfg_irq_mode_i,
  input  logic [1:0]         cfg_irq_band_i,
  input  logic               smp_valid_i,
  input  logic [SEL_W-1:0]   smp_sel_i,
  input  logic [DATA_W-1:0]  smp_data_i,
  input  logic               hrst_i,
  input  logic [SEL_W-1:0]   hrst_sel_i,
  input  logic               hrst_trig_i,
  input  logic               hrst_irq_i,
  input  logic [N_UNITS-1:0] irq_clr_i,
  output logic [N_UNITS-1:0] trig_o,
  output logic [N_UNITS-1:0] irq_status_o
);
  cond_t trig_cfg, irq_cfg;

  assign trig_cfg = '{mode: mode_e'(cfg_trig_mode_i), band: band_e'(cfg_trig_band_i)};
  assign irq_cfg  = '{mode: mode_e'(cfg_irq_mode_i),  band: band_e'(cfg_irq_band_i)};

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    logic hit_cfg, hit_smp, hit_hrst;

    assign hit_cfg  = cfg_we_i    && (cfg_sel_i  == SEL_W'(i));
    assign hit_smp  = smp_valid_i && (smp_sel_i  == SEL_W'(i));
    assign hit_hrst = hrst_i      && (hrst_sel_i == SEL_W'(i));

    wcmp_unit #(.DATA_W(DATA_W)) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (hit_cfg),
      .cfg_lo_i   (cfg_lo_i),
      .cfg_hi_i   (cfg_hi_i),
      .trig_cfg_i (trig_cfg),
      .irq_cfg_i  (irq_cfg),
      .smp_we_i   (hit_smp),
      .smp_i      (smp_data_i),
      .hrst_trig_i(hit_hrst && hrst_trig_i),
      .hrst_irq_i (hit_hrst && hrst_irq_i),
      .irq_clr_i  (irq_clr_i[i]),
      .trig_o     (trig_o[i]),
      .irq_o      (irq_status_o[i])
    );
  end
endmodule

// File: rtl/wcmp_bank_chk.sv
module wcmp_bank_chk #(
  parameter int N_UNITS = 8,
  parameter int SEL_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               smp_valid_i,
  input logic [SEL_W-1:0]   smp_sel_i,
  input logic [N_UNITS-1:0] irq_clr_i,
  input logic [N_UNITS-1:0] trig_o,
  input logic [N_UNITS-1:0] irq_status_o
);
  // R2: a trigger pulse needs a sample strobe on the previous edge
  p_trig_needs_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o != '0) |-> $past(smp_valid_i));

  // R10: only the selected unit can pulse
  p_trig_routed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o != '0) |-> (trig_o == (N_UNITS'(1) << $past(smp_sel_i))));

  // R7: uncleared status bits hold
  p_irq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_status_o & ~irq_clr_i) != '0) |=>
    ((irq_status_o & $past(irq_status_o & ~irq_clr_i)) == $past(irq_status_o & ~irq_clr_i)));

  // R7: no status bit rises without a sample
  p_irq_set_needs_sample_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ((irq_status_o & ~$past(irq_status_o)) == '0));

  // R10: at most one status bit rises per edge
  p_irq_set_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_status_o & ~$past(irq_status_o)));
endmodule

bind wcmp_bank wcmp_bank_chk #(.N_UNITS(N_UNITS), .SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_sel_i   (smp_sel_i),
  .irq_clr_i   (irq_clr_i),
  .trig_o      (trig_o),
  .irq_status_o(irq_status_o)
);

// File: tb/wcmp_bank_tb.sv
module wcmp_bank_tb;
  localparam int N  = 8;
  localparam int DW = 12;
  localparam int SW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [SW-1:0] cfg_sel_i = '0;
  logic [DW-1:0] cfg_lo_i = '0, cfg_hi_i = '0;
  logic [1:0]    cfg_trig_mode_i = '0, cfg_trig_band_i = '0;
  logic [1:0]    cfg_irq_mode_i = '0, cfg_irq_band_i = '0;
  logic          smp_valid_i = 1'b0;
  logic [SW-1:0] smp_sel_i = '0;
  logic [DW-1:0] smp_data_i = '0;
  logic          hrst_i = 1'b0;
  logic [SW-1:0] hrst_sel_i = '0;
  logic          hrst_trig_i = 1'b0, hrst_irq_i = 1'b0;
  logic [N-1:0]  irq_clr_i = '0;
  logic [N-1:0]  trig_o, irq_status_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  wcmp_bank #(.N_UNITS(N), .DATA_W(DW)) u_dut (.*);

  typedef struct packed {
    logic [SW-1:0] sel;
    logic [DW-1:0] data;
    logic [N-1:0]  trig;
    logic [N-1:0]  irq;
  } vec_t;

  // unit0: lo 100 hi 200, trig always/high, irq once/low
  // unit1: lo 1000 hi 2000, trig hyst/high, irq hyst-once/low
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 12'd150,  8'h00, 8'h00},
    '{3'd0, 12'd50,   8'h00, 8'h01},
    '{3'd0, 12'd60,   8'h00, 8'h00},
    '{3'd0, 12'd100,  8'h00, 8'h00},
    '{3'd0, 12'd200,  8'h00, 8'h00},
    '{3'd0, 12'd201,  8'h01, 8'h00},
    '{3'd0, 12'd4095, 8'h01, 8'h00},
    '{3'd0, 12'd99,   8'h00, 8'h01},
    '{3'd1, 12'd1500, 8'h00, 8'h00},
    '{3'd1, 12'd500,  8'h00, 8'h00},
    '{3'd1, 12'd1500, 8'h00, 8'h00},
    '{3'd1, 12'd2500, 8'h02, 8'h00},
    '{3'd1, 12'd1500, 8'h02, 8'h00},
    '{3'd1, 12'd2000, 8'h02, 8'h00},
    '{3'd1, 12'd999,  8'h00, 8'h02},
    '{3'd1, 12'd800,  8'h00, 8'h00},
    '{3'd1, 12'd1999, 8'h00, 8'h00},
    '{3'd0, 12'd150,  8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {trig,irq} actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int unit, input int lo, input int hi,
                     input int tm, input int tb, input int im, input int ib);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = SW'(unit);
    cfg_lo_i = DW'(lo); cfg_hi_i = DW'(hi);
    cfg_trig_mode_i = 2'(tm); cfg_trig_band_i = 2'(tb);
    cfg_irq_mode_i = 2'(im);  cfg_irq_band_i = 2'(ib);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // outputs are read right after return: one edge after the strobe
  task automatic smp(input int unit, input int data, input logic [N-1:0] clr);
    @(negedge clk_i);
    smp_valid_i = 1'b1; smp_sel_i = SW'(unit); smp_data_i = DW'(data); irq_clr_i = clr;
    @(negedge clk_i);
    smp_valid_i = 1'b0; irq_clr_i = '0;
  endtask

  task automatic hrst(input int unit, input logic t, input logic q);
    @(negedge clk_i);
    hrst_i = 1'b1; hrst_sel_i = SW'(unit); hrst_trig_i = t; hrst_irq_i = q;
    @(negedge clk_i);
    hrst_i = 1'b0; hrst_trig_i = 1'b0; hrst_irq_i = 1'b0;
  endtask

  task automatic clr(input logic [N-1:0] m);
    @(negedge clk_i);
    irq_clr_i = m;
    @(negedge clk_i);
    irq_clr_i = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 reset outputs", {trig_o, irq_status_o}, '0);
    rst_ni = 1'b1;

    // R11: unconfigured unit is disabled
    smp(7, 0, '0);
    chk("R11 unconfigured unit silent low", {trig_o, irq_status_o}, '0);
    smp(7, 4095, '0);
    chk("R11 unconfigured unit silent high", {trig_o, irq_status_o}, '0);

    cfg(0, 100, 200, 0, 2, 1, 0);
    cfg(1, 1000, 2000, 2, 2, 3, 0);

    // table covers R1 R2 R3 R4 R5 R10; clear-all each step also exercises set-over-clear
    for (int v = 0; v < NV; v++) begin
      smp(int'(VECS[v].sel), int'(VECS[v].data), '1);
      chk($sformatf("table vector %0d (R1 R2 R3 R4 R5 R10)", v),
          {trig_o, irq_status_o}, {VECS[v].trig, VECS[v].irq});
    end

    // R6: mid target with hysteresis modes, off target
    cfg(2, 10, 20, 2, 1, 3, 1);
    smp(2, 15, '1); chk("R6 hyst mid a", {trig_o, irq_status_o}, '0);
    smp(2, 5,  '1); chk("R6 hyst mid b", {trig_o, irq_status_o}, '0);
    smp(2, 15, '1); chk("R6 hyst mid c", {trig_o, irq_status_o}, '0);
    smp(2, 25, '1); chk("R6 hyst mid d", {trig_o, irq_status_o}, '0);
    smp(2, 15, '1); chk("R6 hyst mid e", {trig_o, irq_status_o}, '0);
    cfg(6, 10, 20, 0, 3, 1, 3);
    smp(6, 30, '1); chk("R6 off target", {trig_o, irq_status_o}, '0);

    // R7 R8: trig off, irq always/high on unit 3
    cfg(3, 10, 20, 0, 3, 0, 2);
    smp(3, 30, '0);
    chk("R7 R8 status set, trig quiet", {trig_o, irq_status_o}, {8'h00, 8'h08});
    repeat (3) @(negedge clk_i);
    chk("R7 status holds", {trig_o, irq_status_o}, {8'h00, 8'h08});
    clr(8'h10);
    chk("R7 other clear no effect", {trig_o, irq_status_o}, {8'h00, 8'h08});
    clr(8'h08);
    chk("R7 cleared", {trig_o, irq_status_o}, '0);
    smp(3, 30, 8'h08);
    chk("R7 set wins over clear", {trig_o, irq_status_o}, {8'h00, 8'h08});
    clr('1);

    // R9: independent history reset on unit 4 (once/high both)
    cfg(4, 10, 20, 1, 2, 1, 2);
    smp(4, 15, '1); chk("R9 prime", {trig_o, irq_status_o}, '0);
    hrst(4, 1'b1, 1'b0);
    smp(4, 30, '1);
    chk("R9 trig history cleared only", {trig_o, irq_status_o}, {8'h00, 8'h10});
    smp(4, 15, '1); chk("R9 back to mid", {trig_o, irq_status_o}, '0);
    hrst(4, 1'b0, 1'b1);
    smp(4, 30, '1);
    chk("R9 irq history cleared only", {trig_o, irq_status_o}, {8'h10, 8'h00});

    // R12: writing unit 5 leaves unit 0 intact
    cfg(5, 3000, 4000, 1, 0, 1, 0);
    smp(0, 300, '1);
    chk("R12 unit0 config kept", {trig_o, irq_status_o}, {8'h01, 8'h00});
    @(negedge clk_i);
    chk("R2 pulse is one cycle", {trig_o, irq_status_o}, '0);

    finish_run();
  end
endmodule